// File: doc/BRIEF.md
# Transmit Gearbox with Fractional Timestamp Correction

This block sits on the transmit side of a 64b/66b line path. Upstream logic hands it 66-bit line blocks split into two beats: a 34-bit header beat (the two sync bits plus the first 32 payload bits), then a 32-bit body beat. The block repacks that bit stream into one 32-bit word per clock. Each 66-bit block leaves 2 bits over, so a small residue builds up in an internal holding register and is sent at the front of later output words. Once the residue passes a full word, the block stalls its input for one cycle and sends the residue out as a word of its own.

Every header beat carries a two-step timestamp taken when its sync bits are handed over. The bits already held in the gearbox delay those sync bits by a fraction of a cycle. The block measures that delay as the held bit count n (the gearbox sequence state, 0 to 32 in steps of 2). It adds period × n / 32 to the timestamp and presents the corrected value with a one-cycle strobe at a fixed latency.

Back-pressure rules: a beat transfers on a rising clock edge when `in_valid` and `in_ready` are both high. While `in_valid` is high and the beat has not transferred, upstream must hold `in_data` and `in_ts` steady. `in_ready` depends only on internal state, never on `in_valid`. The line side cannot stall: `out_valid` marks the cycles that carry a word, and no ready signal comes back.

Top module: `tx_gearbox_tscomp`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0 and `ts_valid` is 0, and no bits are held.
- R2: Beats alternate, and the first beat accepted after reset is a header beat. A header beat contributes all 34 bits of `in_data`, bit 0 first, with the sync bits in `in_data[1:0]`. A body beat contributes `in_data[31:0]`, and `in_data[33:32]` on a body beat has no effect on the output stream.
- R3: The concatenation of all output words, each sent bit 0 first, equals the concatenation of all accepted beat bits, with no bit lost, repeated or reordered.
- R4: A word is emitted whenever the held bits plus the bits of a beat accepted at that edge reach 32. `out_valid` rises in the cycle after that edge and stays 0 in every cycle that carries no word.
- R5: `in_ready` is 0 exactly when more than 32 bits are held (the only such value is 34). A stall never lasts more than one cycle. Under continuous input there is one stall cycle per 16 blocks (33 output words).
- R6: The correction count n for a block equals the number of bits held when its header beat is accepted. It is even and lies between 0 and 32.
- R7: The corrected timestamp is `(in_ts + ((PERIOD_FX × n) >> 5)) mod 2^TS_W`. `PERIOD_FX` is the word clock period in unsigned nanoseconds with 16 fractional bits (default 203358, about 3.103 ns).
- R8: `ts_valid` is high for exactly one cycle per block, two cycles after the edge that accepted its header beat, and is low at all other times.
- R9: The first block after reset is corrected by n = 0, so its timestamp is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat on `in_data` is valid |
| in_ready | output | 1 | Block can accept a beat this cycle |
| in_data | input | 34 | Header beat: sync in [1:0], payload in [33:2]; body beat: payload in [31:0] |
| in_ts | input | 64 | Timestamp of the block, read with its header beat |
| out_valid | output | 1 | `out_data` carries a line word |
| out_data | output | 32 | Line word, bit 0 sent first |
| ts_valid | output | 1 | One-cycle strobe for `ts_out` |
| ts_out | output | 64 | Corrected timestamp |

## Verification
A wrong held-bit count shows up at the ports in two ways. The next output word comes out shifted or carries stale bits. The next header beat gets a correction off by a multiple of period/16 two cycles later. A beat-phase error shows first as payload bits in the sync positions, and then as a strobe for a body beat. Rebuilding the bit stream from the output words, and computing n from bit positions alone, catches either fault within one word or one block of where it arises. Reset and starvation gaps are exercised so that the zero-offset and drain-only paths are covered.

// File: rtl/tx_gearbox_tscomp_pkg.sv
package tx_gearbox_tscomp_pkg;

  // Which half of a 66-bit line block the next accepted beat is.
  typedef enum logic {
    BEAT_HDR  = 1'b0,
    BEAT_BODY = 1'b1
  } beat_e;

  // Number of stream bits a beat contributes.
  function automatic int unsigned beat_width(beat_e kind, int unsigned word_w,
                                             int unsigned hdr_w);
    return (kind == BEAT_HDR) ? (word_w + hdr_w) : word_w;
  endfunction

endpackage

// File: rtl/gbx_beat_tracker.sv
module gbx_beat_tracker
  import tx_gearbox_tscomp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_ready,
  output logic accept,
  output logic is_hdr
);

  beat_e beat_q;

  assign accept = in_valid & in_ready;
  assign is_hdr = (beat_q == BEAT_HDR);

  // Toggle between header and body on every transfer.
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= BEAT_HDR;
    end else if (accept) begin
      beat_q <= (beat_q == BEAT_HDR) ? BEAT_BODY : BEAT_HDR;
    end
  end

endmodule

// File: rtl/gbx_bit_buffer.sv
module gbx_bit_buffer
  import tx_gearbox_tscomp_pkg::*;
#(
  parameter  int WORD_W = 32,
  parameter  int HDR_W  = 2,
  localparam int BEAT_W = WORD_W + HDR_W,
  localparam int BUF_W  = 2 * WORD_W + HDR_W,
  localparam int CNT_W  = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              is_hdr,
  input  logic [BEAT_W-1:0] in_data,
  output logic              in_ready,
  output logic [CNT_W-1:0]  held_bits,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);

  logic [BUF_W-1:0]  hold_q;
  logic [CNT_W-1:0]  fill_q;
  logic [WORD_W-1:0] word_q;
  logic              word_vld_q;

  logic [BUF_W-1:0]  ext;
  logic [BUF_W-1:0]  merged;
  logic [BUF_W-1:0]  hold_d;
  logic [CNT_W-1:0]  inc;
  logic [CNT_W-1:0]  total;
  logic [CNT_W-1:0]  fill_d;
  logic              emit;

  // Accept a beat only while the residue leaves room for a full header beat.
  assign in_ready  = (fill_q <= CNT_W'(WORD_W));
  assign held_bits = fill_q;

  always_comb begin
    ext = '0;
    inc = '0;
    if (accept) begin
      if (is_hdr) begin
        ext[BEAT_W-1:0] = in_data;
        inc = CNT_W'(beat_width(BEAT_HDR, WORD_W, HDR_W));
      end else begin
        ext[WORD_W-1:0] = in_data[WORD_W-1:0];
        inc = CNT_W'(beat_width(BEAT_BODY, WORD_W, HDR_W));
      end
    end
    // New bits land just above the residue, which is sent first.
    merged = hold_q | (ext << fill_q);
    total  = fill_q + inc;
    emit   = (total >= CNT_W'(WORD_W));
    if (emit) begin
      hold_d = merged >> WORD_W;
      fill_d = total - CNT_W'(WORD_W);
    end else begin
      hold_d = merged;
      fill_d = total;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      fill_q     <= '0;
      word_q     <= '0;
      word_vld_q <= 1'b0;
    end else begin
      hold_q     <= hold_d;
      fill_q     <= fill_d;
      word_vld_q <= emit;
      if (emit) begin
        word_q <= merged[WORD_W-1:0];
      end
    end
  end

  assign out_valid = word_vld_q;
  assign out_data  = word_q;

endmodule

// File: rtl/gbx_ts_corrector.sv
module gbx_ts_corrector #(
  parameter int          WORD_W    = 32,
  parameter int          TS_W      = 64,
  parameter int          CNT_W     = 7,
  parameter logic [31:0] PERIOD_FX = 32'd203358,
  localparam int         SHIFT     = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [TS_W-1:0]  in_ts,
  input  logic [CNT_W-1:0] offset_bits,
  output logic             ts_valid,
  output logic [TS_W-1:0]  ts_out
);

  logic            vld1_q;
  logic [TS_W-1:0] ts1_q;
  logic [TS_W-1:0] prod1_q;
  logic [TS_W-1:0] corr;
  logic            vld2_q;
  logic [TS_W-1:0] ts2_q;

  // Stage 1: capture the raw stamp and period x n.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld1_q  <= 1'b0;
      ts1_q   <= '0;
      prod1_q <= '0;
    end else begin
      vld1_q <= take;
      if (take) begin
        ts1_q   <= in_ts;
        prod1_q <= TS_W'(PERIOD_FX) * TS_W'(offset_bits);
      end
    end
  end

  // Scale by 1/WORD_W: a shift when it is a power of two, else a divide.
  generate
    if ((1 << SHIFT) == WORD_W) begin : g_shift
      assign corr = prod1_q >> SHIFT;
    end else begin : g_divide
      assign corr = prod1_q / TS_W'(WORD_W);
    end
  endgenerate

  // Stage 2: registered sum and strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld2_q <= 1'b0;
      ts2_q  <= '0;
    end else begin
      vld2_q <= vld1_q;
      if (vld1_q) begin
        ts2_q <= ts1_q + corr;
      end
    end
  end

  assign ts_valid = vld2_q;
  assign ts_out   = ts2_q;

endmodule

// File: rtl/tx_gearbox_tscomp.sv
module tx_gearbox_tscomp #(
  parameter int          WORD_W    = 32,
  parameter int          HDR_W     = 2,
  parameter int          TS_W      = 64,
  parameter logic [31:0] PERIOD_FX = 32'd203358
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W+HDR_W-1:0] in_data,
  input  logic [TS_W-1:0]         in_ts,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_data,
  output logic                    ts_valid,
  output logic [TS_W-1:0]         ts_out
);

  localparam int BUF_W = 2 * WORD_W + HDR_W;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic             accept;
  logic             beat_is_hdr;
  logic [CNT_W-1:0] held_bits;

  gbx_beat_tracker beat_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .is_hdr   (beat_is_hdr)
  );

  gbx_bit_buffer #(
    .WORD_W (WORD_W),
    .HDR_W  (HDR_W)
  ) buf_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .is_hdr    (beat_is_hdr),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .held_bits (held_bits),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // The held count at header acceptance is the sequence offset n.
  gbx_ts_corrector #(
    .WORD_W    (WORD_W),
    .TS_W      (TS_W),
    .CNT_W     (CNT_W),
    .PERIOD_FX (PERIOD_FX)
  ) corr_i (
    .clk         (clk),
    .rst         (rst),
    .take        (accept & beat_is_hdr),
    .in_ts       (in_ts),
    .offset_bits (held_bits),
    .ts_valid    (ts_valid),
    .ts_out      (ts_out)
  );

endmodule

// File: rtl/tx_gearbox_tscomp_chk.sv
module tx_gearbox_tscomp_chk #(
  parameter int          WORD_W    = 32,
  parameter int          TS_W      = 64,
  parameter int          CNT_W     = 7,
  parameter logic [31:0] PERIOD_FX = 32'd203358
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [TS_W-1:0]  in_ts,
  input logic             out_valid,
  input logic             ts_valid,
  input logic [TS_W-1:0]  ts_out,
  input logic             hdr_phase,
  input logic [CNT_W-1:0] held_bits
);

  logic hdr_take;
  assign hdr_take = in_valid && in_ready && hdr_phase;

  // R1: outputs quiet in the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !ts_valid));

  // R5: a stall cycle is always followed by readiness
  p_single_stall_r5: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  // R6: sequence offset even and within one word
  p_seq_range_r6: assert property (@(posedge clk) disable iff (rst)
    hdr_take |-> (held_bits <= CNT_W'(WORD_W) && !held_bits[0]));

  // R8: a strobe only two cycles after a header transfer
  p_ts_latency_r8: assert property (@(posedge clk) disable iff (rst)
    ts_valid |-> $past(hdr_take, 2));

  // R7: correction never exceeds one period
  p_corr_bound_r7: assert property (@(posedge clk) disable iff (rst)
    ts_valid |-> ((ts_out - $past(in_ts, 2)) <= TS_W'(PERIOD_FX)));

endmodule

bind tx_gearbox_tscomp tx_gearbox_tscomp_chk #(
  .WORD_W    (WORD_W),
  .TS_W      (TS_W),
  .CNT_W     (CNT_W),
  .PERIOD_FX (PERIOD_FX)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_ts     (in_ts),
  .out_valid (out_valid),
  .ts_valid  (ts_valid),
  .ts_out    (ts_out),
  .hdr_phase (beat_is_hdr),
  .held_bits (held_bits)
);

// File: tb/tx_gearbox_tscomp_tb_top.sv
module tx_gearbox_tscomp_tb_top;

  localparam int          W   = 32;
  localparam int          H   = 2;
  localparam int          TW  = 64;
  localparam logic [31:0] PER = 32'd203358;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W+H-1:0] in_data = '0;
  logic [TW-1:0] in_ts = '0;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          ts_valid;
  logic [TW-1:0] ts_out;

  // 50 MHz: 20-unit period
  always #10 clk = ~clk;

  tx_gearbox_tscomp dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ts(in_ts), .out_valid(out_valid),
    .out_data(out_data), .ts_valid(ts_valid), .ts_out(ts_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  bit            exp_bits[$];
  logic [TW-1:0] exp_ts_q[$];
  int            exp_due_q[$];
  bit            exp_first_q[$];
  int            nk;
  int            model_fill;
  bit            model_hdr;
  bit            exp_emit;
  bit            hold;
  bit            first_blk;

  task automatic chk(input bit ok, input string req, input logic [TW-1:0] act,
                     input logic [TW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] corrected(input logic [TW-1:0] ts, input int n);
    return ts + ((TW'(PER) * TW'(n)) >> 5);
  endfunction

  task automatic observe();
    logic [W-1:0] w;
    logic [TW-1:0] e;
    bit f;
    // R4: word presence follows the bit count
    chk(out_valid == exp_emit, "R4 out_valid", TW'(out_valid), TW'(exp_emit));
    if (exp_emit) begin
      w = '0;
      if (exp_bits.size() < W) begin
        chk(1'b0, "R3 stream underflow", TW'(exp_bits.size()), TW'(W));
      end else begin
        for (int i = 0; i < W; i++) w[i] = exp_bits.pop_front();
        // R3 order, with R2 beat layout (body upper bits must be dropped)
        chk(out_data == w, "R3 word (R2 layout)", TW'(out_data), TW'(w));
      end
      model_fill -= W;
    end
    if (exp_due_q.size() > 0 && exp_due_q[0] == nk) begin
      void'(exp_due_q.pop_front());
      e = exp_ts_q.pop_front();
      f = exp_first_q.pop_front();
      chk(ts_valid, "R8 ts_valid missing", TW'(ts_valid), 64'd1);
      if (f) chk(ts_out == e, "R9 first block ts", ts_out, e);
      else   chk(ts_out == e, "R6/R7 corrected ts", ts_out, e);
    end else begin
      chk(!ts_valid, "R8 spurious ts_valid", TW'(ts_valid), 64'd0);
    end
    // R5: readiness from the held bit count
    chk(in_ready == (model_fill <= W), "R5 in_ready", TW'(in_ready),
        TW'(model_fill <= W));
  endtask

  task automatic drive(input int pct);
    bit acc;
    int inc;
    if (!hold) begin
      in_valid = ($urandom_range(99) < pct);
      in_data  = {2'($urandom), $urandom};
      in_ts    = {$urandom, $urandom};
    end
    acc  = in_valid && in_ready;
    hold = in_valid && !in_ready;
    inc  = 0;
    if (acc) begin
      if (model_hdr) begin
        exp_ts_q.push_back(corrected(in_ts, model_fill));
        exp_due_q.push_back(nk + 2);
        exp_first_q.push_back(first_blk);
        first_blk = 1'b0;
        for (int i = 0; i < W + H; i++) exp_bits.push_back(in_data[i]);
        inc = W + H;
      end else begin
        for (int i = 0; i < W; i++) exp_bits.push_back(in_data[i]);
        inc = W;
      end
      model_hdr = !model_hdr;
    end
    model_fill += inc;
    exp_emit = (model_fill >= W);
  endtask

  task automatic step(input int pct);
    @(negedge clk);
    nk++;
    observe();
    drive(pct);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_bits.delete();
    exp_ts_q.delete();
    exp_due_q.delete();
    exp_first_q.delete();
    nk = 0; model_fill = 0; model_hdr = 1'b1; exp_emit = 1'b0;
    hold = 1'b0; first_blk = 1'b1;
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready", TW'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R1 out_valid", TW'(out_valid), 64'd0);
    chk(ts_valid == 1'b0, "R1 ts_valid", TW'(ts_valid), 64'd0);
    drive(0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd1588));
    do_reset();
    // Continuous stream: periodic stalls and full n sweep (R5, R6, R9)
    repeat (700) step(100);
    // Random valid with back-pressure
    repeat (1500) step(70);
    // Sparse input: starvation and drain-only words (R4)
    repeat (800) step(15);
    // Reset mid-stream, then first block again at n = 0 (R1, R9)
    do_reset();
    repeat (300) step(100);
    repeat (500) step(50);
    // Flush: no new input, let pending stamps and words drain
    repeat (8) step(0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      finish_run();
    end
  end

endmodule